// File: doc/BRIEF.md
# Two-Bank SDRAM Command Sequence Monitor

This block watches the command bus of a two-bank synchronous DRAM without driving anything. Every clock it decodes the active-low chip select, row strobe, column strobe and write enable together with the address lines. It keeps a small model of each bank: idle, active, in an auto-precharge burst, or precharging. It also keeps two global lockouts, one after a mode register load and one after an auto-refresh. When a command breaks a sequencing rule, the block raises a sticky error flag for that rule.

A 4-bit code keeps the first violation seen since the last clear. A separate counter checks that enough auto-refresh commands arrive in each refresh window. The monitor is meant to sit beside a memory controller, either in simulation or in silicon, and report protocol faults. It does not model stored data.

The timing windows, the refresh window length and the refresh quota are all parameters. The defaults are 128 ms worth of 125 MHz cycles and 4096 refreshes.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Commands are decoded from {cs_n, ras_n, cas_n, we_n} as follows: 0000 mode load, 0001 auto-refresh, 0010 precharge, 0011 activate, 0100 write, 0101 read, 0110 burst stop, 0111 no-op. Any pattern with cs_n high is a deselect. A no-op or a deselect never raises a flag, whatever the other lines carry.
- R2: A mode load or auto-refresh while either bank is active sets err_flags[0] (code 1).
- R3: A read or write to the bank named by the top address bit (A11) sets err_flags[1] (code 2) when that bank is not active.
- R4: Any command other than no-op or deselect issued k cycles after a mode load, with k < T_MCD, sets err_flags[2] (code 3).
- R5: A precharge with A10 high covers both banks. With A10 low it covers only the bank named by A11. For k < T_RP cycles after it, the following set err_flags[3] (code 4): an activate, read or write to a covered bank, or a mode load or auto-refresh.
- R6: Any command other than no-op or deselect issued k cycles after an auto-refresh, with k < T_RC, sets err_flags[4] (code 5).
- R7: An activate to a bank that is already active sets err_flags[5] (code 6).
- R8: A read or write with A10 high keeps the bank active for D cycles and then precharges it for T_RP cycles. For a read, D = CL + BL; for a write, D = BL. BL and CL come from the last mode load: BL field A2..A0 gives 1, 2, 4, 8 for codes 0 to 3 and 8 above. CL is A6..A4, with 0 read as 1. The reset values are BL 1 and CL 2. A read or write with A10 low leaves the bank active.
- R9: Windows of REF_WINDOW cycles run back to back from reset. A window that closes with fewer than REF_QUOTA auto-refresh commands sets err_flags[6] (code 7).
- R10: Flags are sticky until clr_err is high on a clock edge. A clear clears all flags and the code, and wins over an error raised in the same cycle. err_code holds the first violation since the last clear; when several rules fail together, the lowest flag index wins. err_code is 0 exactly when no flag is set, and reset clears everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_err | input | 1 | Synchronous clear of flags and code |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Address lines; the top bit selects the bank, the next one is the auto/all-bank bit |
| err_flags | output | 7 | Sticky per-rule error flags |
| err_code | output | 4 | Code of the first violation, 0 when none |

## Verification
The main stimulus is a continuous command stream with one command per clock. The stream places commands exactly one cycle inside and exactly on the edge of each lockout, so an off-by-one in any timer shows up as a flag that is missing or extra. Reads and writes with auto-precharge are followed by accesses on both sides of the point where precharge begins. Because the read span and the write span differ under the same mode setting, CAS latency is separated from burst length. A deselect carrying an illegal-looking pattern sits inside a precharge window, and a clear lands in the same cycle as a fault. Two refresh windows, one meeting the quota and one just short of it, confirm the starvation boundary.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

   typedef enum logic [3:0] {
      CMD_DESEL,
      CMD_NOP,
      CMD_MRS,
      CMD_ACT,
      CMD_PRE,
      CMD_RD,
      CMD_WR,
      CMD_REF,
      CMD_BST
   } cmd_t;

   localparam int NUM_ERR    = 7;
   localparam int CODE_W     = 4;
   localparam int E_NOT_IDLE = 0;
   localparam int E_NOT_ACT  = 1;
   localparam int E_MCD      = 2;
   localparam int E_RP       = 3;
   localparam int E_RC       = 4;
   localparam int E_DBL_ACT  = 5;
   localparam int E_STARVE   = 6;

   // lowest set flag index wins; code = index + 1
   function automatic logic [CODE_W-1:0] first_code(input logic [NUM_ERR-1:0] v);
      logic [CODE_W-1:0] c;
      c = '0;
      for (int i = NUM_ERR - 1; i >= 0; i--) begin
         if (v[i]) c = CODE_W'(i + 1);
      end
      return c;
   endfunction

   function automatic logic [3:0] burst_len(input logic [2:0] code);
      logic [3:0] r;
      if (code[2]) r = 4'd8;
      else         r = 4'(1 << code[1:0]);
      return r;
   endfunction

   function automatic logic [2:0] cas_lat(input logic [2:0] code);
      return (code == 3'd0) ? 3'd1 : code;
   endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_mon_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_t cmd
);
   always_comb begin
      if (cs_n) begin
         cmd = CMD_DESEL;
      end else begin
         case ({ras_n, cas_n, we_n})
            3'b000:  cmd = CMD_MRS;
            3'b001:  cmd = CMD_REF;
            3'b010:  cmd = CMD_PRE;
            3'b011:  cmd = CMD_ACT;
            3'b100:  cmd = CMD_WR;
            3'b101:  cmd = CMD_RD;
            3'b110:  cmd = CMD_BST;
            default: cmd = CMD_NOP;
         endcase
      end
   end
endmodule

// File: rtl/sdram_lock_timer.sv
module sdram_lock_timer #(
   parameter int SPAN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = (SPAN < 2) ? 1 : $clog2(SPAN + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt_q <= '0;
      else if (start)           cnt_q <= CW'(SPAN - 1);
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
   import sdram_mon_pkg::*;
#(
   parameter int T_RP   = 3,
   parameter int SPAN_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  cmd_t              cmd,
   input  logic              ap,
   input  logic [SPAN_W-1:0] span,
   output logic              active,
   output logic              prech
);
   localparam int CNT_W = $clog2((1 << SPAN_W) + T_RP + 1);

   logic             act_q, act_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   // cnt counts down to idle; the last T_RP steps are the precharge
   always_comb begin
      act_d = act_q;
      cnt_d = cnt_q;
      if (cnt_q != '0) begin
         cnt_d = cnt_q - 1'b1;
         if (cnt_q == CNT_W'(1)) act_d = 1'b0;
      end
      if (hit) begin
         case (cmd)
            CMD_ACT: begin
               act_d = 1'b1;
               cnt_d = '0;
            end
            CMD_PRE: begin
               act_d = 1'b0;
               cnt_d = CNT_W'(T_RP - 1);
            end
            CMD_RD, CMD_WR: begin
               if (ap) cnt_d = CNT_W'(span) + CNT_W'(T_RP - 1);
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         act_q <= act_d;
         cnt_q <= cnt_d;
      end
   end

   assign prech  = (cnt_q != '0) && (cnt_q <= CNT_W'(T_RP));
   assign active = act_q && !prech;
endmodule

// File: rtl/sdram_ref_window.sv
module sdram_ref_window #(
   parameter int WINDOW = 16_000_000,
   parameter int QUOTA  = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_seen,
   output logic starve
);
   localparam int WIN_W = $clog2(WINDOW);
   localparam int QW    = $clog2(QUOTA + 1);

   logic [WIN_W-1:0] win_q;
   logic [QW-1:0]    cnt_q;
   logic             last, met;

   assign last = (win_q == WIN_W'(WINDOW - 1));
   assign met  = (cnt_q == QW'(QUOTA)) ||
                 (ref_seen && (cnt_q == QW'(QUOTA - 1)));
   assign starve = last && !met;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q <= '0;
         cnt_q <= '0;
      end else if (last) begin
         win_q <= '0;
         cnt_q <= '0;
      end else begin
         win_q <= win_q + 1'b1;
         if (ref_seen && (cnt_q != QW'(QUOTA))) cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
   import sdram_mon_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int T_MCD       = 2,
   parameter int T_RP        = 3,
   parameter int T_RC        = 7,
   parameter int REF_WINDOW  = 16_000_000,
   parameter int REF_QUOTA   = 4096,
   parameter int BL_CODE_RST = 0,
   parameter int CL_CODE_RST = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_err,
   input  logic               cs_n,
   input  logic               ras_n,
   input  logic               cas_n,
   input  logic               we_n,
   input  logic [ADDR_W-1:0]  addr,
   output logic [6:0]         err_flags,
   output logic [3:0]         err_code
);
   localparam int BANK_BITS = 1;
   localparam int NUM_BANKS = 1 << BANK_BITS;
   localparam int SPAN_W    = 4;
   localparam int BANK_POS  = ADDR_W - 1;
   localparam int AP_POS    = ADDR_W - 2;

   if (ADDR_W < 10)     begin : g_bad_addr  $error("ADDR_W must be at least 10"); end
   if (T_MCD < 1)       begin : g_bad_mcd   $error("T_MCD must be at least 1");   end
   if (T_RP < 1)        begin : g_bad_rp    $error("T_RP must be at least 1");    end
   if (T_RC < 1)        begin : g_bad_rc    $error("T_RC must be at least 1");    end
   if (REF_WINDOW < 2)  begin : g_bad_win   $error("REF_WINDOW must be at least 2"); end
   if (REF_QUOTA < 1)   begin : g_bad_quota $error("REF_QUOTA must be at least 1"); end
   if (NUM_ERR != 7)    begin : g_bad_nerr  $error("flag port width mismatch");  end

   cmd_t cmd;
   logic bank_sel, ap;
   logic is_cmd, is_mrs, is_ref, is_rw, is_act;
   logic mcd_busy, rc_busy, starve;
   logic [NUM_BANKS-1:0] bank_active, bank_prech;
   logic [2:0] bl_code_q, cl_code_q;
   logic [SPAN_W-1:0] rd_span, wr_span, sel_span;
   logic [NUM_ERR-1:0] err_vec, flags_q;
   logic [CODE_W-1:0] code_q;
   logic unused_addr_bits;

   assign unused_addr_bits = ^{addr[3], addr[ADDR_W-3:7]};

   sdram_cmd_decode u_dec (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (cmd)
   );

   assign bank_sel = addr[BANK_POS];
   assign ap       = addr[AP_POS];
   assign is_cmd   = (cmd != CMD_NOP) && (cmd != CMD_DESEL);
   assign is_mrs   = (cmd == CMD_MRS);
   assign is_ref   = (cmd == CMD_REF);
   assign is_rw    = (cmd == CMD_RD) || (cmd == CMD_WR);
   assign is_act   = (cmd == CMD_ACT);

   // mode fields captured at every mode load
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bl_code_q <= 3'(BL_CODE_RST);
         cl_code_q <= 3'(CL_CODE_RST);
      end else if (is_mrs) begin
         bl_code_q <= addr[2:0];
         cl_code_q <= addr[6:4];
      end
   end

   assign wr_span  = burst_len(bl_code_q);
   assign rd_span  = wr_span + SPAN_W'(cas_lat(cl_code_q));
   assign sel_span = (cmd == CMD_RD) ? rd_span : wr_span;

   sdram_lock_timer #(.SPAN(T_MCD)) u_mcd (
      .clk   (clk),
      .rst_n (rst_n),
      .start (is_mrs),
      .busy  (mcd_busy)
   );

   sdram_lock_timer #(.SPAN(T_RC)) u_rc (
      .clk   (clk),
      .rst_n (rst_n),
      .start (is_ref),
      .busy  (rc_busy)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      assign hit = (bank_sel == BANK_BITS'(b)) || ((cmd == CMD_PRE) && ap);
      sdram_bank_track #(.T_RP(T_RP), .SPAN_W(SPAN_W)) u_trk (
         .clk    (clk),
         .rst_n  (rst_n),
         .hit    (hit),
         .cmd    (cmd),
         .ap     (ap),
         .span   (sel_span),
         .active (bank_active[b]),
         .prech  (bank_prech[b])
      );
   end

   sdram_ref_window #(.WINDOW(REF_WINDOW), .QUOTA(REF_QUOTA)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_seen (is_ref),
      .starve   (starve)
   );

   always_comb begin
      err_vec             = '0;
      err_vec[E_NOT_IDLE] = (is_mrs || is_ref) && (|bank_active);
      err_vec[E_NOT_ACT]  = is_rw && !bank_active[bank_sel];
      err_vec[E_MCD]      = is_cmd && mcd_busy;
      err_vec[E_RP]       = ((is_act || is_rw) && bank_prech[bank_sel]) ||
                            ((is_mrs || is_ref) && (|bank_prech));
      err_vec[E_RC]       = is_cmd && rc_busy;
      err_vec[E_DBL_ACT]  = is_act && bank_active[bank_sel];
      err_vec[E_STARVE]   = starve;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr_err) begin
         flags_q <= '0;
         code_q  <= '0;
      end else begin
         flags_q <= flags_q | err_vec;
         if ((code_q == '0) && (|err_vec)) code_q <= first_code(err_vec);
      end
   end

   assign err_flags = flags_q;
   assign err_code  = code_q;
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
   parameter int T_MCD = 2,
   parameter int T_RC  = 7
) (
   input logic       clk,
   input logic       rst_n,
   input logic       clr_err,
   input logic       cs_n,
   input logic       ras_n,
   input logic       cas_n,
   input logic       we_n,
   input logic       bank_bit,
   input logic [6:0] err_flags,
   input logic [3:0] err_code
);
   logic p_mrs, p_ref, p_act, p_cmd;
   assign p_mrs = !cs_n && !ras_n && !cas_n && !we_n;
   assign p_ref = !cs_n && !ras_n && !cas_n &&  we_n;
   assign p_act = !cs_n && !ras_n &&  cas_n &&  we_n;
   assign p_cmd = !cs_n && !(ras_n && cas_n && we_n);

   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_err |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_err |=> (err_flags == 7'd0) && (err_code == 4'd0));

   p_code_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((err_code != 4'd0) && !clr_err) |=> $stable(err_code));

   p_code_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_code == 4'd0) == (err_flags == 7'd0));

   p_act_twice_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (p_act ##1 (p_act && (bank_bit == $past(bank_bit)) && !clr_err)) |=> err_flags[5]);

   if (T_MCD >= 2) begin : g_mcd
      p_mcd_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (p_mrs ##1 (p_cmd && !clr_err)) |=> err_flags[2]);
   end

   if (T_RC >= 2) begin : g_rc
      p_rc_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (p_ref ##1 (p_cmd && !clr_err)) |=> err_flags[4]);
   end
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(
   .T_MCD (T_MCD),
   .T_RC  (T_RC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr_err   (clr_err),
   .cs_n      (cs_n),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .we_n      (we_n),
   .bank_bit  (addr[ADDR_W-1]),
   .err_flags (err_flags),
   .err_code  (err_code)
);

// File: tb/tb_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module tb_sdram_cmd_monitor;
   localparam int ADDR_W = 12;
   localparam int WIN    = 200;
   localparam int NV     = 49;

   typedef struct packed {
      logic        clr;
      logic [3:0]  cmd;
      logic [11:0] addr;
      logic [6:0]  flags;
      logic [3:0]  code;
   } vec_t;

   // cmd nibble {cs,ras,cas,we}: 0 MRS,1 REF,2 PRE,3 ACT,4 WR,5 RD,6 BST,7 NOP,8 deselect
   localparam vec_t VEC [NV] = '{
      '{1'b0, 4'h7, 12'h000, 7'h00, 4'd0},  // R1 nop
      '{1'b0, 4'h0, 12'h021, 7'h00, 4'd0},  // R8 mode: BL2 CL2
      '{1'b0, 4'h7, 12'h000, 7'h00, 4'd0},  // R4 nop inside lock
      '{1'b0, 4'h3, 12'h005, 7'h00, 4'd0},  // R4 act at k=T_MCD
      '{1'b0, 4'h5, 12'h000, 7'h00, 4'd0},  // R3 read active bank0
      '{1'b0, 4'h4, 12'h800, 7'h02, 4'd2},  // R3 write idle bank1
      '{1'b1, 4'h7, 12'h000, 7'h00, 4'd0},  // R10 clear
      '{1'b0, 4'h3, 12'h000, 7'h20, 4'd6},  // R7 act active bank
      '{1'b1, 4'h7, 12'h000, 7'h00, 4'd0},
      '{1'b0, 4'h1, 12'h000, 7'h01, 4'd1},  // R2 refresh with bank0 active
      '{1'b1, 4'h7, 12'h000, 7'h00, 4'd0},
      '{1'b0, 4'h7, 12'h000, 7'h00, 4'd0},
      '{1'b0, 4'h7, 12'h000, 7'h00, 4'd0},
      '{1'b0, 4'h2, 12'h000, 7'h00, 4'd0},  // R6 pre bank0 at k=T_RC
      '{1'b0, 4'h3, 12'h000, 7'h08, 4'd4},  // R5 act during precharge
      '{1'b1, 4'h7, 12'h000, 7'h00, 4'd0},
      '{1'b0, 4'h2, 12'h400, 7'h00, 4'd0},  // R5 precharge all
      '{1'b0, 4'h7, 12'h000, 7'h00, 4'd0},
      '{1'b0, 4'h7, 12'h000, 7'h00, 4'd0},
      '{1'b0, 4'h3, 12'h800, 7'h00, 4'd0},  // R5 act bank1 at k=T_RP
      '{1'b0, 4'h0, 12'h021, 7'h01, 4'd1},  // R2 mode with bank1 active
      '{1'b0, 4'h2, 12'h800, 7'h05, 4'd1},  // R4 pre inside lock, code kept (R10)
      '{1'b1, 4'h7, 12'h000, 7'h00, 4'd0},
      '{1'b0, 4'h7, 12'h000, 7'h00, 4'd0},
      '{1'b0, 4'h1, 12'h000, 7'h00, 4'd0},  // R2 refresh all idle
      '{1'b0, 4'h6, 12'h000, 7'h10, 4'd5},  // R6 burst stop in refresh lock
      '{1'b1, 4'h7, 12'h000, 7'h00, 4'd0},
      '{1'b0, 4'h7, 12'h000, 7'h00, 4'd0},
      '{1'b0, 4'h7, 12'h000, 7'h00, 4'd0},
      '{1'b0, 4'h3, 12'h000, 7'h00, 4'd0},
      '{1'b0, 4'h5, 12'h400, 7'h00, 4'd0},  // R8 read auto-precharge, D=4
      '{1'b0, 4'h7, 12'h000, 7'h00, 4'd0},
      '{1'b0, 4'h7, 12'h000, 7'h00, 4'd0},
      '{1'b0, 4'h5, 12'h000, 7'h00, 4'd0},  // R8 k=3 still active
      '{1'b0, 4'h5, 12'h000, 7'h0A, 4'd2},  // R8 k=4 precharging
      '{1'b1, 4'h7, 12'h000, 7'h00, 4'd0},
      '{1'b0, 4'h7, 12'h000, 7'h00, 4'd0},
      '{1'b0, 4'h3, 12'h000, 7'h00, 4'd0},  // R8 k=D+T_RP idle
      '{1'b0, 4'h4, 12'h400, 7'h00, 4'd0},  // R8 write auto-precharge, D=2
      '{1'b0, 4'h7, 12'h000, 7'h00, 4'd0},
      '{1'b0, 4'h5, 12'h000, 7'h0A, 4'd2},  // R8 k=2 precharging
      '{1'b1, 4'h7, 12'h000, 7'h00, 4'd0},
      '{1'b0, 4'h7, 12'h000, 7'h00, 4'd0},
      '{1'b0, 4'h3, 12'h000, 7'h00, 4'd0},  // R8 k=5 idle
      '{1'b0, 4'h7, 12'h000, 7'h00, 4'd0},
      '{1'b0, 4'h2, 12'h000, 7'h00, 4'd0},  // R5 pre bank0
      '{1'b0, 4'h8, 12'h000, 7'h00, 4'd0},  // R1 deselect with low strobes
      '{1'b0, 4'h3, 12'h000, 7'h08, 4'd4},  // R5 act k=2
      '{1'b1, 4'h7, 12'h000, 7'h00, 4'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr_err = 1'b0;
   logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic [6:0] err_flags;
   logic [3:0] err_code;

   int n_vec = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sdram_cmd_monitor #(
      .ADDR_W     (ADDR_W),
      .T_MCD      (2),
      .T_RP       (3),
      .T_RC       (4),
      .REF_WINDOW (WIN),
      .REF_QUOTA  (2)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_err   (clr_err),
      .cs_n      (cs_n),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .we_n      (we_n),
      .addr      (addr),
      .err_flags (err_flags),
      .err_code  (err_code)
   );

   task automatic drive(input logic [3:0] c, input logic [11:0] a, input logic clr);
      {cs_n, ras_n, cas_n, we_n} = c;
      addr    = a;
      clr_err = clr;
   endtask

   task automatic check(input string req, input logic [6:0] ef, input logic [3:0] ec);
      n_vec++;
      if (err_flags !== ef || err_code !== ec) begin
         n_fail++;
         $display("FAIL %s: flags=%h code=%0d, expected flags=%h code=%0d",
                  req, err_flags, err_code, ef, ec);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         drive(4'h7, 12'h000, 1'b0);
         @(negedge clk);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_vec++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      drive(4'h7, 12'h000, 1'b0);
      repeat (3) @(negedge clk);
      check("R10 reset state", 7'h00, 4'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].cmd, VEC[i].addr, VEC[i].clr);
         @(negedge clk);
         check($sformatf("R1-table row %0d", i), VEC[i].flags, VEC[i].code);
      end

      // R10: clear wins against a same-cycle fault on idle bank1
      drive(4'h5, 12'h800, 1'b1);
      @(negedge clk);
      check("R10 clear beats fault", 7'h00, 4'd0);
      drive(4'h5, 12'h800, 1'b0);
      @(negedge clk);
      check("R3 read idle bank1", 7'h02, 4'd2);
      idle(2);
      check("R10 flags stay sticky", 7'h02, 4'd2);
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 reset clears", 7'h00, 4'd0);
      rst_n = 1'b1;

      // R9: first window gets two refreshes, second gets one
      idle(5);
      drive(4'h1, 12'h000, 1'b0);
      @(negedge clk);
      idle(10);
      drive(4'h1, 12'h000, 1'b0);
      @(negedge clk);
      idle(190);
      check("R9 quota met", 7'h00, 4'd0);
      drive(4'h1, 12'h000, 1'b0);
      @(negedge clk);
      idle(180);
      check("R9 before window end", 7'h00, 4'd0);
      idle(20);
      check("R9 starvation", 7'h40, 4'd7);

      finish_run();
   end
endmodule